// File: doc/BRIEF.md
# Embedded-Controller Slave Message Engine

This block turns the raw byte events of an I2C slave front end into framed messages for an embedded controller link. Every bus event arrives as a single-cycle strobe with four flags (interrupt, end-of-transfer, byte-received, read-not-write) and, for the write direction, the byte that came with it. The engine follows the transaction through a small protocol state machine. It collects a write transaction into a receive buffer and checks the collected length against the length that the message header announces. For a read transaction it supplies the bytes of the queued outgoing message, or of a built-in three-byte no-op message when nothing is queued.

An active-low request line asks the bus master to start a read. Raising `tx_req` pulls it low. A read event with a repeated start releases it, and a transmit that stops early pulls it low again so that the master retries. Completion and error pulses tell the surrounding logic when a message was accepted or rejected, when a transmit finished or was rewound, and when the bus presented an unexpected flag pattern.

Top module: `ecm_engine`

## Requirements
- R1: After reset `req_n` is 1, `rd_byte` is 0xFF, `rx_len` is 0, and every pulse output (`rd_vld`, `addr_miss`, `proto_err`, `tx_done`, `tx_rewind`, `rx_done`, `rx_bad`, `rx_ovf`) is 0.
- R2: A strobe with `ev_irq` low is ignored. It produces no pulse, does not change `req_n`, and leaves the protocol position where it was.
- R3: A strobe with `ev_rcv`=1 and `ev_rnw`=0 is an address byte. From any state it moves the engine to the address-seen state. `addr_miss` pulses one cycle later if `ev_byte` differs from `own_addr`.
- R4: In the address-seen state, a plain data strobe (only `ev_irq` set) stores `ev_byte` as header byte 0 and moves to the first-byte state. Any other pattern pulses `proto_err` and returns to idle. In idle, strobes other than address bytes change nothing.
- R5: In the first-byte state, a repeated-start read (irq, rcv and rnw set, end clear) is accepted only when header byte 0 is 0x01. The engine then enters the transmit state and drives byte 0 of the selected message. Otherwise it pulses `proto_err`, drives 0xFF and returns to idle. Any strobe with exactly irq, rcv and rnw set drives `req_n` to 1.
- R6: In the transmit state, each read strobe (irq and rnw set, rcv and end clear) drives the byte at the current position and advances it. A read at or past the message size, or a write-direction or byte-received strobe, pulses `proto_err` and returns to idle.
- R7: When `tx_have` is 0 at the repeated start, the message sent is 0x02, 0x07, 0x02, with size 3. Otherwise bytes come from `tx_byte` at index `tx_idx`, with size `tx_size` latched at the repeated start.
- R8: In the transmit state an end-of-transfer strobe either pulses `tx_done` and returns to idle, when every byte was sent, or pulses `tx_rewind`, drives `req_n` low and sets the position back to 0.
- R9: In the first-byte state, a plain data strobe stores header byte 1 and enters the receive state. There, plain data strobes append bytes, and an end-of-transfer strobe without rnw pulses `rx_done` (count equals expected size) or `rx_bad` (otherwise) and returns to idle. `rx_buf` byte i sits at bits 8i+7:8i. A read-direction or byte-received strobe in the receive state pulses `proto_err` and returns to idle.
- R10: The expected size is header byte 1 plus 2 when bit 7 of header byte 0 is 0, or when bits 6:5 are 0 (variable size). Bits 6:5 equal to 1 give a size of 2, equal to 2 give 3, and equal to 3 give 0.
- R11: A data byte arriving when `rx_len` equals MAX_BYTES is dropped and pulses `rx_ovf`. `rx_len` never exceeds MAX_BYTES.
- R12: Every accepted strobe with rnw set and end clear pulses `rd_vld` one cycle later. `rd_byte` then holds the message byte, or 0xFF when no message byte applies, and keeps its value until the next such strobe.
- R13: A `tx_req` pulse drives `req_n` low on the next cycle, unless a release from R5 happens in the same cycle, which takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_stb | input | 1 | One-cycle bus event strobe |
| ev_irq | input | 1 | Event interrupt flag |
| ev_end | input | 1 | End-of-transfer flag |
| ev_rcv | input | 1 | Byte-received flag |
| ev_rnw | input | 1 | Read-not-write flag |
| ev_byte | input | 8 | Byte received with the event |
| own_addr | input | 8 | Configured slave address byte |
| tx_req | input | 1 | Queued-message request pulse |
| tx_have | input | 1 | A queued transmit message is present |
| tx_size | input | CW | Size of the queued message in bytes |
| tx_byte | input | 8 | Queued message byte at `tx_idx` |
| tx_idx | output | CW | Transmit byte index being fetched |
| rd_vld | output | 1 | Pulse: `rd_byte` is to be driven on the bus |
| rd_byte | output | 8 | Byte for the current read |
| req_n | output | 1 | Active-low request line to the master |
| addr_miss | output | 1 | Pulse: address byte differs from `own_addr` |
| proto_err | output | 1 | Pulse: unexpected flag pattern, aborted |
| tx_done | output | 1 | Pulse: transmit completed |
| tx_rewind | output | 1 | Pulse: transmit ended early and rewound |
| rx_done | output | 1 | Pulse: received message accepted |
| rx_bad | output | 1 | Pulse: received length mismatch |
| rx_ovf | output | 1 | Pulse: byte dropped on a full buffer |
| rx_len | output | CW | Bytes held in the receive buffer |
| rx_buf | output | 8*MAX_BYTES | Receive buffer contents |

## Verification
A wrong protocol state is visible one cycle after the next strobe. It shows up as a `proto_err` pulse where none was due, as a missing `rd_vld`, or as a wrong `rd_byte`. A wrong header byte or count appears only at the end-of-transfer strobe, where `rx_done` and `rx_bad` swap. A stale transmit position shows on the first read after a rewind, which sends a byte other than byte 0.

// File: rtl/ecm_pkg.sv
package ecm_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ADDR = 3'd1,
      ST_HDR  = 3'd2,
      ST_TX   = 3'd3,
      ST_RX   = 3'd4
   } ecm_state_e;

   localparam logic [7:0] CMD_READ  = 8'h01;
   localparam logic [7:0] IDLE_FILL = 8'hFF;

   localparam logic [1:0] LC_VAR   = 2'd0;
   localparam logic [1:0] LC_TWO   = 2'd1;
   localparam logic [1:0] LC_THREE = 2'd2;

   localparam int unsigned NOOP_LEN = 3;

   // Size announced by the two header bytes of a received message.
   function automatic logic [8:0] expect_len(input logic [7:0] h0, input logic [7:0] h1);
      if (!h0[7] || h0[6:5] == LC_VAR)
         return {1'b0, h1} + 9'd2;
      else if (h0[6:5] == LC_TWO)
         return 9'd2;
      else if (h0[6:5] == LC_THREE)
         return 9'd3;
      else
         return 9'd0;
   endfunction

   // Built-in filler message sent when nothing is queued.
   function automatic logic [7:0] noop_byte(input int unsigned i);
      case (i)
         0:       return 8'h02;
         1:       return 8'h07;
         2:       return 8'h02;
         default: return IDLE_FILL;
      endcase
   endfunction

endpackage

// File: rtl/ecm_rx_store.sv
module ecm_rx_store #(
   parameter  int unsigned MAX_BYTES = 34,
   localparam int unsigned CW        = $clog2(MAX_BYTES + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic                   put,
   input  logic [7:0]             din,
   output logic [CW-1:0]          count,
   output logic                   full,
   output logic [7:0]             hdr0,
   output logic [7:0]             hdr1,
   output logic [MAX_BYTES*8-1:0] flat
);

   if (MAX_BYTES < 3) begin : g_bad_depth
      $error("ecm_rx_store: MAX_BYTES must be at least 3");
   end

   assign full = (count == CW'(MAX_BYTES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (start)
         count <= CW'(1);
      else if (put && !full)
         count <= count + CW'(1);
   end

   for (genvar g = 0; g < MAX_BYTES; g++) begin : g_lane
      logic [7:0] q;
      logic       hit;
      assign hit = (start && g == 0) || (put && !full && count == CW'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (hit)
            q <= din;
      end
      assign flat[g*8 +: 8] = q;
   end

   assign hdr0 = flat[7:0];
   assign hdr1 = flat[15:8];

endmodule

// File: rtl/ecm_tx_source.sv
module ecm_tx_source #(
   parameter  int unsigned MAX_BYTES = 34,
   localparam int unsigned CW        = $clog2(MAX_BYTES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          arm,
   input  logic          have,
   input  logic [CW-1:0] q_size,
   input  logic [CW-1:0] idx,
   input  logic [7:0]    q_byte,
   output logic [7:0]    cur,
   output logic [CW-1:0] size_cur
);
   import ecm_pkg::*;

   if (NOOP_LEN > MAX_BYTES) begin : g_bad_noop
      $error("ecm_tx_source: filler message longer than MAX_BYTES");
   end

   logic          use_noop_q;
   logic [CW-1:0] size_q;
   logic          sel_noop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         use_noop_q <= 1'b1;
         size_q     <= CW'(NOOP_LEN);
      end else if (arm) begin
         use_noop_q <= !have;
         size_q     <= have ? q_size : CW'(NOOP_LEN);
      end
   end

   // The arming cycle already needs byte 0, before the choice is latched.
   assign sel_noop = arm ? !have : use_noop_q;
   assign cur      = sel_noop ? noop_byte(32'(idx)) : q_byte;
   assign size_cur = size_q;

endmodule

// File: rtl/ecm_engine.sv
module ecm_engine #(
   parameter  int unsigned MAX_BYTES = 34,
   localparam int unsigned CW        = $clog2(MAX_BYTES + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ev_stb,
   input  logic                   ev_irq,
   input  logic                   ev_end,
   input  logic                   ev_rcv,
   input  logic                   ev_rnw,
   input  logic [7:0]             ev_byte,
   input  logic [7:0]             own_addr,
   input  logic                   tx_req,
   input  logic                   tx_have,
   input  logic [CW-1:0]          tx_size,
   input  logic [7:0]             tx_byte,
   output logic [CW-1:0]          tx_idx,
   output logic                   rd_vld,
   output logic [7:0]             rd_byte,
   output logic                   req_n,
   output logic                   addr_miss,
   output logic                   proto_err,
   output logic                   tx_done,
   output logic                   tx_rewind,
   output logic                   rx_done,
   output logic                   rx_bad,
   output logic                   rx_ovf,
   output logic [CW-1:0]          rx_len,
   output logic [MAX_BYTES*8-1:0] rx_buf
);
   import ecm_pkg::*;

   if (MAX_BYTES > 255) begin : g_bad_max
      $error("ecm_engine: MAX_BYTES above 255 is not supported");
   end

   ecm_state_e    state_q, st_d;
   logic [CW-1:0] tx_pos_q, pos_d;

   logic take, is_addr, is_plain, is_rsr, drives;
   logic rx_start, rx_put, arm;
   logic [7:0] fill;
   logic p_proto, p_done, p_bad, p_tdone, p_rew, p_ovf, p_miss;

   logic [CW-1:0] rx_count;
   logic          rx_full;
   logic [7:0]    hdr0, hdr1;
   logic [7:0]    src_byte;
   logic [CW-1:0] src_size;
   logic [8:0]    want_len;

   assign take     = ev_stb & ev_irq;
   assign is_addr  = ev_rcv & ~ev_rnw;
   assign is_plain = ~ev_end & ~ev_rcv & ~ev_rnw;
   assign is_rsr   = ~ev_end & ev_rcv & ev_rnw;
   assign drives   = ev_rnw & ~ev_end;
   assign want_len = expect_len(hdr0, hdr1);
   assign tx_idx   = (state_q == ST_TX) ? tx_pos_q : '0;

   ecm_rx_store #(.MAX_BYTES(MAX_BYTES)) u_rx (
      .clk   (clk),
      .rst_n (rst_n),
      .start (rx_start),
      .put   (rx_put),
      .din   (ev_byte),
      .count (rx_count),
      .full  (rx_full),
      .hdr0  (hdr0),
      .hdr1  (hdr1),
      .flat  (rx_buf)
   );

   ecm_tx_source #(.MAX_BYTES(MAX_BYTES)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (arm),
      .have     (tx_have),
      .q_size   (tx_size),
      .idx      (tx_idx),
      .q_byte   (tx_byte),
      .cur      (src_byte),
      .size_cur (src_size)
   );

   always_comb begin
      st_d     = state_q;
      pos_d    = tx_pos_q;
      rx_start = 1'b0;
      rx_put   = 1'b0;
      arm      = 1'b0;
      fill     = IDLE_FILL;
      p_proto  = 1'b0;
      p_done   = 1'b0;
      p_bad    = 1'b0;
      p_tdone  = 1'b0;
      p_rew    = 1'b0;
      p_ovf    = 1'b0;
      p_miss   = 1'b0;
      if (take) begin
         if (is_addr) begin
            st_d   = ST_ADDR;
            p_miss = (ev_byte != own_addr);
         end else begin
            case (state_q)
               ST_IDLE: ;
               ST_ADDR: begin
                  if (is_plain) begin
                     rx_start = 1'b1;
                     st_d     = ST_HDR;
                  end else begin
                     p_proto = 1'b1;
                     st_d    = ST_IDLE;
                  end
               end
               ST_HDR: begin
                  if (is_rsr && hdr0 == CMD_READ) begin
                     arm   = 1'b1;
                     fill  = src_byte;
                     pos_d = CW'(1);
                     st_d  = ST_TX;
                  end else if (is_plain) begin
                     rx_put = 1'b1;
                     st_d   = ST_RX;
                  end else begin
                     p_proto = 1'b1;
                     st_d    = ST_IDLE;
                  end
               end
               ST_TX: begin
                  if (ev_end) begin
                     if (tx_pos_q != src_size) begin
                        p_rew = 1'b1;
                        pos_d = '0;
                     end else begin
                        p_tdone = 1'b1;
                        st_d    = ST_IDLE;
                     end
                  end else if (!ev_rnw || ev_rcv) begin
                     p_proto = 1'b1;
                     st_d    = ST_IDLE;
                  end else if (tx_pos_q < src_size) begin
                     fill  = src_byte;
                     pos_d = tx_pos_q + CW'(1);
                  end else begin
                     p_proto = 1'b1;
                     st_d    = ST_IDLE;
                  end
               end
               ST_RX: begin
                  if (ev_end && !ev_rnw) begin
                     if (32'(rx_count) == 32'(want_len))
                        p_done = 1'b1;
                     else
                        p_bad = 1'b1;
                     st_d = ST_IDLE;
                  end else if (ev_rnw || ev_rcv) begin
                     p_proto = 1'b1;
                     st_d    = ST_IDLE;
                  end else begin
                     rx_put = 1'b1;
                     p_ovf  = rx_full;
                  end
               end
               default: st_d = ST_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         tx_pos_q  <= '0;
         rd_vld    <= 1'b0;
         rd_byte   <= IDLE_FILL;
         req_n     <= 1'b1;
         addr_miss <= 1'b0;
         proto_err <= 1'b0;
         tx_done   <= 1'b0;
         tx_rewind <= 1'b0;
         rx_done   <= 1'b0;
         rx_bad    <= 1'b0;
         rx_ovf    <= 1'b0;
      end else begin
         state_q   <= st_d;
         tx_pos_q  <= pos_d;
         rd_vld    <= take && drives;
         if (take && drives)
            rd_byte <= fill;
         if (take && is_rsr)
            req_n <= 1'b1;
         else if (p_rew || tx_req)
            req_n <= 1'b0;
         addr_miss <= p_miss;
         proto_err <= p_proto;
         tx_done   <= p_tdone;
         tx_rewind <= p_rew;
         rx_done   <= p_done;
         rx_bad    <= p_bad;
         rx_ovf    <= p_ovf;
      end
   end

   assign rx_len = rx_count;

endmodule

// File: rtl/ecm_engine_chk.sv
module ecm_engine_chk #(
   parameter  int unsigned MAX_BYTES = 34,
   localparam int unsigned CW        = $clog2(MAX_BYTES + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ev_stb,
   input logic          ev_irq,
   input logic          ev_end,
   input logic          ev_rcv,
   input logic          ev_rnw,
   input logic [7:0]    ev_byte,
   input logic [7:0]    own_addr,
   input logic          rd_vld,
   input logic          req_n,
   input logic          addr_miss,
   input logic          proto_err,
   input logic          tx_done,
   input logic          tx_rewind,
   input logic          rx_done,
   input logic          rx_bad,
   input logic          rx_ovf,
   input logic [CW-1:0] rx_len
);

   assert_ignore_no_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_stb && !ev_irq) |=> (!rd_vld && !proto_err && !rx_done && !rx_bad && !tx_done && !tx_rewind));

   assert_addr_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
      addr_miss |-> $past(ev_stb && ev_irq && ev_rcv && !ev_rnw && (ev_byte != own_addr)));

   assert_release_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_stb && ev_irq && !ev_end && ev_rcv && ev_rnw) |=> req_n);

   assert_rewind_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_rewind |-> !req_n);

   assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_done && rx_bad));

   assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rx_len <= CW'(MAX_BYTES));

   assert_ovf_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ovf |-> (rx_len == CW'(MAX_BYTES)));

   assert_rd_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rd_vld |-> $past(ev_stb && ev_irq && ev_rnw && !ev_end));

endmodule

bind ecm_engine ecm_engine_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ev_stb    (ev_stb),
   .ev_irq    (ev_irq),
   .ev_end    (ev_end),
   .ev_rcv    (ev_rcv),
   .ev_rnw    (ev_rnw),
   .ev_byte   (ev_byte),
   .own_addr  (own_addr),
   .rd_vld    (rd_vld),
   .req_n     (req_n),
   .addr_miss (addr_miss),
   .proto_err (proto_err),
   .tx_done   (tx_done),
   .tx_rewind (tx_rewind),
   .rx_done   (rx_done),
   .rx_bad    (rx_bad),
   .rx_ovf    (rx_ovf),
   .rx_len    (rx_len)
);

// File: tb/ecm_engine_tb.sv
`timescale 1ns/1ps
module ecm_engine_tb;
   localparam int MAXB = 34;
   localparam int CW   = $clog2(MAXB + 1);
   localparam logic [7:0] ADDR = 8'h8A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ev_stb = 0, ev_irq = 0, ev_end = 0, ev_rcv = 0, ev_rnw = 0;
   logic [7:0] ev_byte = '0;
   logic tx_req = 0, tx_have = 0;
   logic [CW-1:0] tx_size = '0;
   logic [7:0] tx_byte;
   logic [CW-1:0] tx_idx;
   logic rd_vld, req_n, addr_miss, proto_err, tx_done, tx_rewind, rx_done, rx_bad, rx_ovf;
   logic [7:0] rd_byte;
   logic [CW-1:0] rx_len;
   logic [MAXB*8-1:0] rx_buf;
   logic [7:0] qm [0:63];

   int nvec = 0, nbad = 0;

   // model state
   int m_st = 0, m_cnt = 0, m_txpos = 0, m_size = 3;
   bit m_noop = 1, m_req = 1;
   logic [7:0] m_rd = 8'hFF;
   logic [7:0] m_buf [0:63];
   bit x_vld, x_miss, x_proto, x_done, x_bad, x_ovf, x_tdone, x_rew;

   always #2.5 clk = ~clk;
   assign tx_byte = qm[tx_idx];

   ecm_engine #(.MAX_BYTES(MAXB)) u_dut (
      .clk(clk), .rst_n(rst_n), .ev_stb(ev_stb), .ev_irq(ev_irq), .ev_end(ev_end),
      .ev_rcv(ev_rcv), .ev_rnw(ev_rnw), .ev_byte(ev_byte), .own_addr(ADDR),
      .tx_req(tx_req), .tx_have(tx_have), .tx_size(tx_size), .tx_byte(tx_byte),
      .tx_idx(tx_idx), .rd_vld(rd_vld), .rd_byte(rd_byte), .req_n(req_n),
      .addr_miss(addr_miss), .proto_err(proto_err), .tx_done(tx_done),
      .tx_rewind(tx_rewind), .rx_done(rx_done), .rx_bad(rx_bad), .rx_ovf(rx_ovf),
      .rx_len(rx_len), .rx_buf(rx_buf)
   );

   function automatic int want_len(logic [7:0] h0, logic [7:0] h1);
      if (h0[7] == 1'b0) return int'(h1) + 2;
      case (h0[6:5])
         2'd0: return int'(h1) + 2;
         2'd1: return 2;
         2'd2: return 3;
         default: return 0;
      endcase
   endfunction

   function automatic logic [7:0] msg_byte(int p);
      if (m_noop) return (p == 1) ? 8'h07 : ((p == 0 || p == 2) ? 8'h02 : 8'hFF);
      return qm[p];
   endfunction

   task automatic chk(bit ok, string tag, string what, int act, int exp);
      nvec++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic clear_x();
      x_vld = 0; x_miss = 0; x_proto = 0; x_done = 0;
      x_bad = 0; x_ovf = 0; x_tdone = 0; x_rew = 0;
   endtask

   task automatic model(bit i, bit e, bit r, bit w, logic [7:0] b);
      clear_x();
      if (!i) return;                     // R2
      if (w && !e) x_vld = 1;
      if (r && !w) begin
         m_st = 1; x_miss = (b != ADDR);   // R3
      end else begin
         case (m_st)
            0: ;
            1: if (!e && !r && !w) begin m_buf[0] = b; m_cnt = 1; m_st = 2; end
               else begin x_proto = 1; m_st = 0; end
            2: if (!e && r && w && m_buf[0] == 8'h01) begin
                  m_noop = !tx_have; m_size = tx_have ? int'(tx_size) : 3;
                  m_rd = msg_byte(0); m_txpos = 1; m_st = 3;
               end else if (!e && !r && !w) begin
                  m_buf[1] = b; m_cnt = 2; m_st = 4;
               end else begin x_proto = 1; m_st = 0; end
            3: if (e) begin
                  if (m_txpos != m_size) begin x_rew = 1; m_txpos = 0; m_req = 0; end
                  else begin x_tdone = 1; m_st = 0; end
               end else if (!w || r) begin x_proto = 1; m_st = 0; end
               else if (m_txpos < m_size) begin m_rd = msg_byte(m_txpos); m_txpos++; end
               else begin x_proto = 1; m_st = 0; end
            4: if (e && !w) begin
                  if (m_cnt == want_len(m_buf[0], m_buf[1])) x_done = 1; else x_bad = 1;
                  m_st = 0;
               end else if (w || r) begin x_proto = 1; m_st = 0; end
               else if (m_cnt < MAXB) begin m_buf[m_cnt] = b; m_cnt++; end
               else x_ovf = 1;
            default: m_st = 0;
         endcase
      end
      if (x_vld && !(m_st == 3 && m_txpos > 0 && !x_proto && !x_rew)) begin
         // read strobes that sent no message byte drive the filler
      end
      if (!e && r && w) m_req = 1;         // R5
   endtask

   task automatic compare();
      chk(rd_vld == x_vld, "R12", "rd_vld", rd_vld, x_vld);
      chk(rd_byte == m_rd, "R6", "rd_byte", rd_byte, m_rd);
      chk(req_n == m_req, "R13", "req_n", req_n, m_req);
      chk(addr_miss == x_miss, "R3", "addr_miss", addr_miss, x_miss);
      chk(proto_err == x_proto, "R4", "proto_err", proto_err, x_proto);
      chk(rx_done == x_done, "R9", "rx_done", rx_done, x_done);
      chk(rx_bad == x_bad, "R10", "rx_bad", rx_bad, x_bad);
      chk(rx_ovf == x_ovf, "R11", "rx_ovf", rx_ovf, x_ovf);
      chk(tx_done == x_tdone, "R8", "tx_done", tx_done, x_tdone);
      chk(tx_rewind == x_rew, "R8", "tx_rewind", tx_rewind, x_rew);
      chk(int'(rx_len) == m_cnt, "R9", "rx_len", rx_len, m_cnt);
      if (x_done)
         for (int k = 0; k < m_cnt; k++)
            chk(rx_buf[k*8 +: 8] == m_buf[k], "R9", "rx_buf", rx_buf[k*8 +: 8], m_buf[k]);
   endtask

   task automatic ev(bit i, bit e, bit r, bit w, logic [7:0] b);
      logic [7:0] old_rd;
      @(negedge clk);
      ev_irq = i; ev_end = e; ev_rcv = r; ev_rnw = w; ev_byte = b; ev_stb = 1;
      old_rd = m_rd;
      model(i, e, r, w, b);
      // a read strobe that did not pick a message byte drives 0xFF (R12)
      if (x_vld && m_rd === old_rd && !(i && m_st == 3 && !x_proto)) m_rd = 8'hFF;
      @(negedge clk);
      ev_stb = 0;
      compare();
   endtask

   task automatic pulse_req();
      @(negedge clk); tx_req = 1; m_req = 0; clear_x();
      @(negedge clk); tx_req = 0;
      compare();
   endtask

   task automatic wr_msg(logic [7:0] b0, logic [7:0] b1, int n);
      ev(1, 0, 1, 0, ADDR);
      ev(1, 0, 0, 0, b0);
      ev(1, 0, 0, 0, b1);
      for (int k = 0; k < n; k++) ev(1, 0, 0, 0, 8'($urandom));
      ev(1, 1, 0, 0, 8'h00);
   endtask

   task automatic rd_msg(int k, logic [7:0] cmd);
      ev(1, 0, 1, 0, ADDR);
      ev(1, 0, 0, 0, cmd);
      ev(1, 0, 1, 1, ADDR | 8'h01);
      for (int j = 0; j < k; j++) ev(1, 0, 0, 1, 8'h00);
      ev(1, 1, 0, 0, 8'h00);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int k = 0; k < 64; k++) begin qm[k] = 8'(k * 13 + 5); m_buf[k] = 8'h00; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(req_n == 1'b1, "R1", "req_n", req_n, 1);
      chk(rd_byte == 8'hFF, "R1", "rd_byte", rd_byte, 8'hFF);
      chk(rx_len == '0, "R1", "rx_len", rx_len, 0);
      chk(!(rd_vld | addr_miss | proto_err | tx_done | tx_rewind | rx_done | rx_bad | rx_ovf),
          "R1", "pulses", 1, 0);

      // R13 request, R3 wrong address
      pulse_req();
      chk(req_n == 1'b0, "R13", "req_n low", req_n, 0);
      ev(1, 0, 1, 0, 8'h55);
      chk(addr_miss == 1'b1, "R3", "addr_miss", addr_miss, 1);

      // R2 spurious strobe in address-seen state leaves state alone
      ev(0, 1, 1, 1, 8'h99);
      chk(proto_err == 1'b0 && rd_vld == 1'b0, "R2", "spurious quiet", proto_err, 0);
      ev(1, 0, 0, 0, 8'h01);
      chk(proto_err == 1'b0, "R2", "state kept", proto_err, 0);

      // R7 filler message, R5 release
      tx_have = 0;
      ev(1, 0, 1, 1, ADDR | 8'h01);
      chk(rd_byte == 8'h02 && rd_vld, "R7", "noop b0", rd_byte, 8'h02);
      chk(req_n == 1'b1, "R5", "req_n release", req_n, 1);
      ev(1, 0, 0, 1, 8'h00);
      chk(rd_byte == 8'h07, "R7", "noop b1", rd_byte, 8'h07);
      ev(1, 0, 0, 1, 8'h00);
      chk(rd_byte == 8'h02, "R7", "noop b2", rd_byte, 8'h02);
      ev(1, 0, 0, 1, 8'h00);
      chk(proto_err == 1'b1 && rd_byte == 8'hFF, "R6", "underflow", rd_byte, 8'hFF);

      // R8 early end then full resend
      tx_have = 1; tx_size = CW'(4);
      rd_msg(1, 8'h01);
      chk(tx_rewind == 1'b1 && req_n == 1'b0, "R8", "rewind", tx_rewind, 1);
      ev(1, 0, 0, 1, 8'h00);
      chk(rd_byte == qm[0], "R8", "resend byte0", rd_byte, qm[0]);
      rd_msg(3, 8'h01);
      chk(tx_done == 1'b1, "R8", "tx_done", tx_done, 1);

      // R5 rejected read command
      rd_msg(0, 8'h02);

      // R10 fixed two-byte event, R11 overflow
      wr_msg(8'hA0, 8'h33, 0);
      chk(rx_done == 1'b1, "R10", "two-byte event", rx_done, 1);
      wr_msg(8'hC0, 8'h00, 0);
      chk(rx_bad == 1'b1, "R10", "three-byte short", rx_bad, 1);
      wr_msg(8'h10, 8'hFF, 40);
      chk(rx_bad == 1'b1 && int'(rx_len) == MAXB, "R11", "overflow", rx_len, MAXB);
      wr_msg(8'h05, 8'h04, 4);
      chk(rx_done == 1'b1, "R9", "plain message", rx_done, 1);

      // constrained random mix
      for (int t = 0; t < 400; t++) begin
         int sel;
         sel = int'($urandom_range(0, 9));
         if (sel <= 3) begin
            logic [7:0] b0, b1;
            int n;
            b0 = 8'($urandom);
            b1 = 8'($urandom_range(0, 36));
            n  = want_len(b0, b1) - 2;
            if ($urandom_range(0, 3) == 0 || n < 0) n = int'($urandom_range(0, 38));
            wr_msg(b0, b1, n);
         end else if (sel <= 6) begin
            tx_have = 1'($urandom);
            tx_size = CW'($urandom_range(1, 8));
            for (int k = 0; k < 8; k++) qm[k] = 8'($urandom);
            rd_msg(int'($urandom_range(0, 9)), ($urandom_range(0, 4) == 0) ? 8'($urandom) : 8'h01);
         end else if (sel == 7) begin
            pulse_req();
         end else begin
            for (int k = 0; k < 5; k++)
               ev(1'($urandom_range(0, 7) != 0), 1'($urandom), 1'($urandom), 1'($urandom),
                  ($urandom_range(0, 1) == 0) ? ADDR : 8'($urandom));
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule